// File: doc/BRIEF.md
# Block Copy and Fill Engine

This engine carries out one 32-byte memory operation per command. It serves the special stores that a processor pipeline turns into bulk moves. In copy mode it fetches a 32-byte source block into an internal staging buffer. It then writes that buffer to a 32-byte destination block. Every read completes before the first write is issued, so overlapping source and destination blocks still receive the original source data. In fill mode no reads take place. A 64-bit pattern, built from two 32-bit words, is written four times across the destination block.

Commands arrive on a plain control interface: start, mode, two addresses, two pattern words, busy and done. Memory traffic leaves on a 64-bit request channel and a read-response channel, and both use valid/ready. On the request channel the engine is the sender. Once it raises `mem_req_valid`, it keeps address, direction and write data unchanged until `mem_req_ready` is seen high at a clock edge. The memory may hold ready low for any number of cycles. On the response channel the engine is the receiver. It allows one read in flight and raises `mem_rsp_ready` only while it waits for that read, so the memory may delay `mem_rsp_valid` for as long as it needs.

Top module: `blkmove_engine`

## Requirements
- R1: While reset is applied, and in the first cycle after it, busy, done, mem_req_valid and mem_rsp_ready are all 0.
- R2: A command with cmd_mode = 0 (copy) issues four read requests (mem_req_write = 0) at source base + 0, 8, 16 and 24, in that order, before any write request.
- R3: After its reads, a copy issues four write requests (mem_req_write = 1) at destination base + 0, 8, 16 and 24. Each write carries the data returned by the read at the same offset.
- R4: A command with cmd_mode = 1 (fill) issues no read. It issues four write requests at destination base + 0, 8, 16 and 24, each with data {cmd_pat_hi, cmd_pat_lo}: cmd_pat_hi in bits 63:32 and cmd_pat_lo in bits 31:0.
- R5: Bits 4:0 of cmd_dst and cmd_src are ignored. The base is the address with those bits cleared, and every request address has bits 2:0 equal to 0.
- R6: busy rises in the cycle after a start is accepted in the idle state. It stays high through the cycle in which done is high, and is 0 in the next cycle. No request is issued while busy is 0.
- R7: A start asserted while busy is 1 is ignored. The running operation keeps its addresses and count, and no second operation follows it.
- R8: done is high for exactly one cycle. That cycle directly follows the clock edge at which the fourth write handshake completes.
- R9: While mem_req_valid is 1 and mem_req_ready is 0, the request stays valid with unchanged address, direction and data. mem_rsp_ready is 1 only while a read is outstanding, and no request is valid at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Start pulse, taken only when idle |
| cmd_mode | input | 1 | 0 = copy, 1 = fill |
| cmd_dst | input | 32 | Destination address (low 5 bits ignored) |
| cmd_src | input | 32 | Source address for copy (low 5 bits ignored) |
| cmd_pat_hi | input | 32 | Fill pattern, upper word |
| cmd_pat_lo | input | 32 | Fill pattern, lower word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Request byte address, 8-byte aligned |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine waits for read data |
| mem_rsp_rdata | input | 64 | Read data |

## Verification
A beat counter that slips shows up at the very next request handshake as a wrong or repeated offset, or as a write that carries another slot's data. A wrongly latched mode shows up in the cycle after the start is accepted, as a read request during a fill or a write before the reads of a copy. A controller stuck in a state holds busy high, so done never rises. A mishandled stall shows up as a request whose fields change while ready is low.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  typedef enum logic {
    BM_COPY = 1'b0,
    BM_FILL = 1'b1
  } bm_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WRITE,
    ST_DONE
  } bm_state_e;

endpackage

// File: rtl/blkmove_fsm.sv
module blkmove_fsm
  import blkmove_pkg::*;
#(
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  output logic              load_o,
  output logic              fill_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              req_valid_o,
  output logic              req_write_o,
  output logic              rsp_ready_o,
  output logic              slot_we_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  bm_state_e         state_q;
  bm_mode_e          mode_q;
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= BM_COPY;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q  <= bm_mode_e'(mode_i);
            beat_q  <= '0;
            state_q <= (bm_mode_e'(mode_i) == BM_FILL) ? ST_WRITE : ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (req_ready_i) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (rsp_valid_i) begin
            if (beat_q == LAST_BEAT) begin
              beat_q  <= '0;
              state_q <= ST_WRITE;
            end else begin
              beat_q  <= beat_q + 1'b1;
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_WRITE: begin
          if (req_ready_i) begin
            if (beat_q == LAST_BEAT) begin
              beat_q  <= '0;
              state_q <= ST_DONE;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign fill_o      = (mode_q == BM_FILL);
  assign beat_o      = beat_q;
  assign req_valid_o = (state_q == ST_RD_REQ) || (state_q == ST_WRITE);
  assign req_write_o = (state_q == ST_WRITE);
  assign rsp_ready_o = (state_q == ST_RD_WAIT);
  assign slot_we_o   = (state_q == ST_RD_WAIT) && rsp_valid_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

endmodule

// File: rtl/blkmove_agen.sv
module blkmove_agen #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int BLOCK_BYTES = 32,
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int BEAT_W = OFF_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic              is_read_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-OFF_W-1:0] dst_base_q;
  logic [ADDR_W-OFF_W-1:0] src_base_q;
  logic                    unused_low;

  assign unused_low = ^{dst_i[OFF_W-1:0], src_i[OFF_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_base_q <= '0;
      src_base_q <= '0;
    end else if (load_i) begin
      dst_base_q <= dst_i[ADDR_W-1:OFF_W];
      src_base_q <= src_i[ADDR_W-1:OFF_W];
    end
  end

  assign addr_o = {(is_read_i ? src_base_q : dst_base_q), beat_i, {BYTE_W{1'b0}}};

endmodule

// File: rtl/blkmove_stage.sv
module blkmove_stage #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [HALF_W-1:0] pat_hi_i,
  input  logic [HALF_W-1:0] pat_lo_i,
  input  logic              we_i,
  input  logic [BEAT_W-1:0] idx_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] wdata_o
);

  logic [DATA_W-1:0] slot [BEATS];
  logic [DATA_W-1:0] pat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pat_q <= '0;
    else if (load_i) pat_q <= {pat_hi_i, pat_lo_i};
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (we_i && (idx_i == BEAT_W'(g)))    q <= rdata_i;
    end
    assign slot[g] = q;
  end

  assign wdata_o = fill_i ? pat_q : slot[idx_i];

endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int BLOCK_BYTES = 32,
  localparam int BEATS  = BLOCK_BYTES / (DATA_W / 8),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_mode,
  input  logic [ADDR_W-1:0] cmd_dst,
  input  logic [ADDR_W-1:0] cmd_src,
  input  logic [HALF_W-1:0] cmd_pat_hi,
  input  logic [HALF_W-1:0] cmd_pat_lo,
  output logic              busy,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);

  logic              load;
  logic              fill;
  logic [BEAT_W-1:0] beat;
  logic              slot_we;

  blkmove_fsm #(.BEATS(BEATS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (cmd_start),
    .mode_i      (cmd_mode),
    .req_ready_i (mem_req_ready),
    .rsp_valid_i (mem_rsp_valid),
    .load_o      (load),
    .fill_o      (fill),
    .beat_o      (beat),
    .req_valid_o (mem_req_valid),
    .req_write_o (mem_req_write),
    .rsp_ready_o (mem_rsp_ready),
    .slot_we_o   (slot_we),
    .busy_o      (busy),
    .done_o      (done)
  );

  blkmove_agen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)) u_agen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .dst_i     (cmd_dst),
    .src_i     (cmd_src),
    .is_read_i (!mem_req_write),
    .beat_i    (beat),
    .addr_o    (mem_req_addr)
  );

  blkmove_stage #(.DATA_W(DATA_W), .BEATS(BEATS)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .pat_hi_i (cmd_pat_hi),
    .pat_lo_i (cmd_pat_lo),
    .we_i     (slot_we),
    .idx_i    (beat),
    .rdata_i  (mem_rsp_rdata),
    .fill_i   (fill),
    .wdata_o  (mem_req_wdata)
  );

endmodule

// File: rtl/blkmove_engine_chk.sv
module blkmove_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int BYTE_W = $clog2(DATA_W / 8)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_ready
);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));

  a_r9_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_req_valid && mem_req_ready && mem_req_write));

  a_r6_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r6_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !mem_rsp_ready));

  a_r6_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  a_r5_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[BYTE_W-1:0] == '0));

endmodule

bind blkmove_engine blkmove_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_ready (mem_rsp_ready)
);

// File: tb/sim_blkmove_engine.sv
`timescale 1ns/1ps
module sim_blkmove_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic        cmd_mode = 1'b0;
  logic [31:0] cmd_dst = '0;
  logic [31:0] cmd_src = '0;
  logic [31:0] cmd_pat_hi = '0;
  logic [31:0] cmd_pat_lo = '0;
  logic        busy, done;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_rdata = '0;

  always #10 clk = ~clk;

  blkmove_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_mode(cmd_mode),
    .cmd_dst(cmd_dst), .cmd_src(cmd_src), .cmd_pat_hi(cmd_pat_hi), .cmd_pat_lo(cmd_pat_lo),
    .busy(busy), .done(done), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int stall = 0;
  int lat = 0;
  logic [63:0] mem [32];
  logic [63:0] snap [32];
  logic [31:0] log_addr [16];
  logic        log_wr [16];
  logic [63:0] log_data [16];
  int          log_cyc [16];
  int          log_n = 0;
  int          done_n = 0;
  int          done_cyc = 0;
  int          hold_viol = 0;
  logic        rd_pend = 1'b0;
  logic        rsp_fire = 1'b0;
  int          rd_cnt = 0;
  int          rd_idx = 0;
  logic        p_stall = 1'b0;
  logic [31:0] p_addr = '0;
  logic        p_wr = 1'b0;
  logic [63:0] p_data = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model and request monitor, all activity on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_fire) begin
        mem_rsp_valid = 1'b0;
        rsp_fire = 1'b0;
        rd_pend = 1'b0;
      end
      if (rd_pend && !mem_rsp_valid) begin
        if (rd_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = mem[rd_idx];
        end else rd_cnt--;
      end
      if (mem_rsp_valid && mem_rsp_ready) rsp_fire = 1'b1;
      if (p_stall && (!mem_req_valid || mem_req_addr != p_addr || mem_req_write != p_wr
                      || mem_req_wdata != p_data)) hold_viol++;
      mem_req_ready = (stall == 0) || (cyc % 3 == 0);
      if (mem_req_valid && mem_req_ready) begin
        if (log_n < 16) begin
          log_addr[log_n] = mem_req_addr;
          log_wr[log_n]   = mem_req_write;
          log_data[log_n] = mem_req_wdata;
          log_cyc[log_n]  = cyc;
        end
        log_n++;
        if (mem_req_write) mem[mem_req_addr[7:3]] = mem_req_wdata;
        else begin
          rd_pend = 1'b1;
          rd_idx = int'(mem_req_addr[7:3]);
          rd_cnt = lat;
        end
      end
      p_stall = mem_req_valid && !mem_req_ready;
      p_addr = mem_req_addr;
      p_wr = mem_req_write;
      p_data = mem_req_wdata;
      if (done) begin
        done_n++;
        done_cyc = cyc;
      end
    end
  end

  task automatic start_cmd(input logic mode, input logic [31:0] dst, input logic [31:0] src,
                           input logic [31:0] hi, input logic [31:0] lo,
                           input int stl, input int lt);
    @(negedge clk);
    for (int i = 0; i < 32; i++) snap[i] = mem[i];
    stall = stl;
    lat = lt;
    log_n = 0;
    done_n = 0;
    hold_viol = 0;
    cmd_mode = mode; cmd_dst = dst; cmd_src = src; cmd_pat_hi = hi; cmd_pat_lo = lo;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk("R6 busy after start", busy, 1'b1);
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk({tag, " R8 done seen"}, done, 1'b1);
    chk({tag, " R6 busy with done"}, busy, 1'b1);
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, done, 1'b0);
    chk({tag, " R6 busy dropped"}, busy, 1'b0);
    chk({tag, " R8 done after last write"}, 64'(done_cyc), 64'(log_cyc[7 < log_n ? 7 : 3] + 1));
    chk({tag, " R9 request held while stalled"}, 64'(hold_viol), 64'd0);
  endtask

  task automatic check_copy(input string tag, input logic [31:0] sb, input logic [31:0] db);
    chk({tag, " R2 request count"}, 64'(log_n), 64'd8);
    for (int k = 0; k < 4; k++) begin
      chk({tag, " R2 read dir"}, log_wr[k], 1'b0);
      chk({tag, " R2 R5 read addr"}, log_addr[k], sb + 32'(8 * k));
      chk({tag, " R3 write dir"}, log_wr[4 + k], 1'b1);
      chk({tag, " R3 R5 write addr"}, log_addr[4 + k], db + 32'(8 * k));
      chk({tag, " R3 write data"}, log_data[4 + k], snap[(sb >> 3) + 32'(k)]);
    end
  endtask

  task automatic check_fill(input string tag, input logic [31:0] db, input logic [63:0] pat);
    chk({tag, " R4 request count"}, 64'(log_n), 64'd4);
    for (int k = 0; k < 4; k++) begin
      chk({tag, " R4 write dir"}, log_wr[k], 1'b1);
      chk({tag, " R4 R5 write addr"}, log_addr[k], db + 32'(8 * k));
      chk({tag, " R4 pattern"}, log_data[k], pat);
    end
  endtask

  task automatic t_reset;
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 done in reset", done, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 req valid", mem_req_valid, 1'b0);
    chk("R1 rsp ready", mem_rsp_ready, 1'b0);
  endtask

  task automatic t_copy_plain;
    start_cmd(1'b0, 32'h0000_00A0, 32'h0000_0040, 32'h0, 32'h0, 0, 0);
    wait_done("copy plain");
    check_copy("copy plain", 32'h40, 32'hA0);
  endtask

  task automatic t_copy_stall;
    start_cmd(1'b0, 32'h0000_00E7, 32'h0000_0013, 32'hFFFF_FFFF, 32'h1, 1, 3);
    wait_done("copy stall");
    check_copy("copy stall", 32'h00, 32'hE0);
  endtask

  task automatic t_copy_overlap;
    start_cmd(1'b0, 32'h0000_0020, 32'h0000_0020, 32'h0, 32'h0, 1, 1);
    wait_done("copy same block");
    check_copy("copy same block", 32'h20, 32'h20);
  endtask

  task automatic t_fill_plain;
    start_cmd(1'b1, 32'h0000_0020, 32'h0000_0080, 32'hDEAD_BEEF, 32'h0123_4567, 0, 0);
    wait_done("fill plain");
    check_fill("fill plain", 32'h20, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_fill_stall;
    start_cmd(1'b1, 32'h0000_007F, 32'h0000_001F, 32'h8000_0001, 32'h7FFF_FFFE, 1, 0);
    wait_done("fill stall");
    check_fill("fill stall", 32'h60, 64'h8000_0001_7FFF_FFFE);
  endtask

  task automatic t_start_busy;
    start_cmd(1'b0, 32'h0000_00C0, 32'h0000_0080, 32'h0, 32'h0, 1, 2);
    repeat (3) @(negedge clk);
    cmd_mode = 1'b1; cmd_dst = 32'h0; cmd_src = 32'h60;
    cmd_pat_hi = 32'hAAAA_AAAA; cmd_pat_lo = 32'h5555_5555;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (6) @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    wait_done("start while busy R7");
    check_copy("start while busy R7", 32'h80, 32'hC0);
    repeat (12) @(negedge clk);
    chk("R7 no extra requests", 64'(log_n), 64'd8);
    chk("R7 single done", 64'(done_n), 64'd1);
    chk("R7 idle afterwards", busy, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++)
      mem[i] = {32'hC0DE_0000 + 32'(i), 32'h1357_0000 ^ (32'(i) * 32'h111)};
    @(negedge clk);
    t_reset();
    t_copy_plain();
    t_copy_stall();
    t_copy_overlap();
    t_fill_plain();
    t_fill_stall();
    t_start_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule